// File: doc/BRIEF.md
# Multiplexed Six-Digit Display Controller

This block is a self-refreshing engine for a six-digit, eight-segment display. A host stores one character per digit position by placing a 3-bit position, a 4-bit BCD code and a decimal-point flag on its inputs and lowering two active-low strobes: a select and a write. The value is taken when either strobe goes back high. The host has no need to revisit the display afterwards. The host-side inputs may change at any time relative to the system clock, so they pass through a synchroniser before use.

A scan counter visits the six stored characters in turn and wraps around. For each one it decodes the code to a segment pattern and raises a single digit-select line. Each digit slot begins with a dark gap in which no digit line and no segment is driven, which stops ghosting on the next digit. Two control inputs shape the output. One freezes the scan on its current state. The other switches the segment drivers off, either to save power or, when pulsed, to dim the display by duty cycle.

Top module: `seg_scan_display`

## Requirements
- R1: When reset is high, all six positions are loaded with code 15 and a cleared point flag. The scan starts at position 0 inside its dark gap, so after reset every digit shows no segments.
- R2: Position codes 0 to 5 select digits 1 to 6. A value is stored when the select and write strobes, after being low together, see either one go high. The stored value is the code, point flag and position that were present while both strobes were low. Values that change in the same cycle as the release are not stored.
- R3: Position codes 6 and 7 store nothing, and all six digits keep their contents.
- R4: While the select strobe is high, pulses on the write strobe store nothing.
- R5: Codes 0 to 9 light the usual numeral shapes. Segment bit 0 is a, bit 1 is b, and so on up to bit 6, which is g. In hex, codes 0 to 9 give 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F.
- R6: Codes 10 to 15 give, in hex, 40 (dash), 79 (E), 76 (H), 38 (L), 73 (P) and 00 (blank).
- R7: The point flag drives segment bit 7 directly.
- R8: At most one digit-select line is high at any time. Positions are shown in the order 0, 1, 2, 3, 4, 5 and then back to 0.
- R9: Each digit slot lasts DIGIT_TICKS clock cycles. The first BLANK_TICKS cycles of the slot are dark, with all select lines and all segments low. The digit is lit for the cycles that remain.
- R10: While the freeze input is high, the scan position and its slot timing hold. The select lines and the segments therefore stay exactly as they are.
- R11: While the segment-off input is high, the segment outputs are zero and the segment output-enable is low. Scanning of the select lines carries on.
- R12: With freeze and segment-off both high (standby), the select lines hold still and the segments stay dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bcd_i | input | 4 | Character code to store |
| dp_i | input | 1 | Decimal-point flag to store |
| addr_i | input | 3 | Digit position (6 and 7 are null) |
| ce_n_i | input | 1 | Select strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| freeze_i | input | 1 | High stops the scan |
| seg_off_i | input | 1 | High switches the segment drivers off |
| seg_o | output | 8 | Segments a..g in bits 0..6, point in bit 7, active high |
| seg_oe_o | output | 1 | Segment driver enable, active high |
| digit_sel_o | output | 6 | One-hot digit select, active high |

## Verification
The case that is hardest to reach is a strobe release in which the position and the code change in the same cycle as the write strobe rises. The stimulus changes all three at one falling clock edge, so they pass through the synchroniser together, and it then checks that the old position received the old code and that the new position was left alone. Freeze is only meaningful while a digit is lit. The bench therefore waits until the select output shows the wanted digit and raises freeze at that same falling edge, well away from the end of the slot.

// File: rtl/disp_pkg.sv
package disp_pkg;

    localparam int NUM_DIGITS = 6;
    localparam int ADDR_W     = 3;
    localparam int CODE_W     = 4;
    localparam int SEG_W      = 8;
    localparam int IDX_W      = $clog2(NUM_DIGITS);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              dp;
    } digit_t;

    localparam int DIGIT_W = $bits(digit_t);

    typedef struct packed {
        logic              ce_n;
        logic              we_n;
        logic [ADDR_W-1:0] addr;
        digit_t            val;
    } host_bus_t;

    localparam digit_t DIGIT_RESET = '{code: 4'hF, dp: 1'b0};

    localparam host_bus_t BUS_IDLE = '{ce_n: 1'b1, we_n: 1'b1,
                                       addr: '0, val: DIGIT_RESET};

    // Segment bits: 0=a 1=b 2=c 3=d 4=e 5=f 6=g
    function automatic logic [6:0] glyph(input logic [CODE_W-1:0] c);
        logic [6:0] s;
        case (c)
            4'h0: s = 7'h3F;
            4'h1: s = 7'h06;
            4'h2: s = 7'h5B;
            4'h3: s = 7'h4F;
            4'h4: s = 7'h66;
            4'h5: s = 7'h6D;
            4'h6: s = 7'h7D;
            4'h7: s = 7'h07;
            4'h8: s = 7'h7F;
            4'h9: s = 7'h6F;
            4'hA: s = 7'h40;
            4'hB: s = 7'h79;
            4'hC: s = 7'h76;
            4'hD: s = 7'h38;
            4'hE: s = 7'h73;
            default: s = 7'h00;
        endcase
        return s;
    endfunction

    function automatic logic [SEG_W-1:0] render(input digit_t d);
        return {d.dp, glyph(d.code)};
    endfunction

endpackage

// File: rtl/host_sync.sv
module host_sync
    import disp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  host_bus_t         bus_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output digit_t            wr_val_o
);

    host_bus_t         stage [SYNC_STAGES];
    host_bus_t         bus_s;
    logic              active;
    logic              act_q;
    logic [ADDR_W-1:0] held_addr;
    digit_t            held_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage[i] <= BUS_IDLE;
        end else begin
            stage[0] <= bus_i;
            for (int i = 1; i < SYNC_STAGES; i++) stage[i] <= stage[i-1];
        end
    end

    assign bus_s  = stage[SYNC_STAGES-1];
    assign active = !bus_s.ce_n && !bus_s.we_n;

    // Remember what was on the bus during the last cycle both strobes were low
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q     <= 1'b0;
            held_addr <= '0;
            held_val  <= DIGIT_RESET;
        end else begin
            act_q <= active;
            if (active) begin
                held_addr <= bus_s.addr;
                held_val  <= bus_s.val;
            end
        end
    end

    assign wr_en_o   = act_q && !active;
    assign wr_addr_o = held_addr;
    assign wr_val_o  = held_val;

    AST_WRITE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> $past(!bus_s.ce_n)); // R4

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |=> !wr_en_o); // R2

endmodule

// File: rtl/digit_store.sv
module digit_store
    import disp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  digit_t            wr_val_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output digit_t            rd_val_o
);

    digit_t                        regs [NUM_DIGITS];
    logic [NUM_DIGITS*DIGIT_W-1:0] flat;

    for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= DIGIT_RESET;
            else if (wr_en_i && wr_addr_i == ADDR_W'(g))
                regs[g] <= wr_val_i;
        end
        assign flat[g*DIGIT_W +: DIGIT_W] = regs[g];
    end

    assign rd_val_o = regs[rd_idx_i];

    AST_NULL_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wr_addr_i >= ADDR_W'(NUM_DIGITS)) |=> $stable(flat)); // R3

    AST_NO_WRITE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(flat)); // R2

endmodule

// File: rtl/scan_timer.sv
module scan_timer
    import disp_pkg::*;
#(
    parameter int DIGIT_TICKS = 16,
    parameter int BLANK_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             blank_o
);

    localparam int CNT_W = $clog2(DIGIT_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            idx_q <= '0;
        end else if (!freeze_i) begin
            if (cnt_q == CNT_W'(DIGIT_TICKS - 1)) begin
                cnt_q <= '0;
                idx_q <= (idx_q == IDX_W'(NUM_DIGITS - 1)) ? '0 : idx_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign idx_o   = idx_q;
    assign blank_o = cnt_q < CNT_W'(BLANK_TICKS);

    AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        freeze_i |=> ($stable(idx_q) && $stable(cnt_q))); // R10

    AST_STEP_IN_GAP: assert property (@(posedge clk) disable iff (rst)
        !$stable(idx_q) |-> blank_o); // R9

    AST_INDEX_RANGE: assert property (@(posedge clk) disable iff (rst)
        idx_q < IDX_W'(NUM_DIGITS)); // R8

endmodule

// File: rtl/seg_scan_display.sv
module seg_scan_display
    import disp_pkg::*;
#(
    parameter int DIGIT_TICKS = 16,
    parameter int BLANK_TICKS = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CODE_W-1:0]     bcd_i,
    input  logic                  dp_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  ce_n_i,
    input  logic                  we_n_i,
    input  logic                  freeze_i,
    input  logic                  seg_off_i,
    output logic [SEG_W-1:0]      seg_o,
    output logic                  seg_oe_o,
    output logic [NUM_DIGITS-1:0] digit_sel_o
);

    host_bus_t         bus;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    digit_t            wr_val;
    logic [IDX_W-1:0]  idx;
    logic              blank;
    digit_t            cur;

    always_comb begin
        bus.ce_n     = ce_n_i;
        bus.we_n     = we_n_i;
        bus.addr     = addr_i;
        bus.val.code = bcd_i;
        bus.val.dp   = dp_i;
    end

    host_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .bus_i     (bus),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_val_o  (wr_val)
    );

    digit_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_val_i  (wr_val),
        .rd_idx_i  (idx),
        .rd_val_o  (cur)
    );

    scan_timer #(.DIGIT_TICKS(DIGIT_TICKS), .BLANK_TICKS(BLANK_TICKS)) u_scan (
        .clk      (clk),
        .rst      (rst),
        .freeze_i (freeze_i),
        .idx_o    (idx),
        .blank_o  (blank)
    );

    assign digit_sel_o = blank ? '0 : (NUM_DIGITS'(1) << idx);
    assign seg_o       = (blank || seg_off_i) ? '0 : render(cur);
    assign seg_oe_o    = !seg_off_i;

    AST_ONE_DIGIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(digit_sel_o)); // R8

    AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        seg_off_i |-> (seg_o == '0 && !seg_oe_o)); // R11

    AST_DARK_GAP: assert property (@(posedge clk) disable iff (rst)
        (digit_sel_o == '0) |-> (seg_o == '0)); // R9

endmodule

// File: tb/test_seg_scan_display.sv
module test_seg_scan_display;
    import disp_pkg::*;

    localparam int DT = 16;
    localparam int BT = 4;
    localparam int NV = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bcd_i = '0;
    logic       dp_i = 1'b0;
    logic [2:0] addr_i = '0;
    logic       ce_n_i = 1'b1;
    logic       we_n_i = 1'b1;
    logic       freeze_i = 1'b0;
    logic       seg_off_i = 1'b0;
    logic [7:0] seg_o;
    logic       seg_oe_o;
    logic [5:0] digit_sel_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    seg_scan_display #(.DIGIT_TICKS(DT), .BLANK_TICKS(BT)) i_seg_scan_display (
        .clk(clk), .rst(rst), .bcd_i(bcd_i), .dp_i(dp_i), .addr_i(addr_i),
        .ce_n_i(ce_n_i), .we_n_i(we_n_i), .freeze_i(freeze_i),
        .seg_off_i(seg_off_i), .seg_o(seg_o), .seg_oe_o(seg_oe_o),
        .digit_sel_o(digit_sel_o)
    );

    // {addr[2:0], code[3:0], dp, expected segments[7:0]}
    localparam logic [15:0] VEC [NV] = '{
        {3'd0, 4'h0, 1'b0, 8'h3F}, {3'd1, 4'h1, 1'b0, 8'h06},
        {3'd2, 4'h2, 1'b1, 8'hDB}, {3'd3, 4'h3, 1'b0, 8'h4F},
        {3'd4, 4'h4, 1'b0, 8'h66}, {3'd5, 4'h5, 1'b1, 8'hED},
        {3'd0, 4'h6, 1'b0, 8'h7D}, {3'd1, 4'h7, 1'b0, 8'h07},
        {3'd2, 4'h8, 1'b0, 8'h7F}, {3'd3, 4'h9, 1'b1, 8'hEF},
        {3'd4, 4'hA, 1'b0, 8'h40}, {3'd5, 4'hB, 1'b0, 8'h79},
        {3'd0, 4'hC, 1'b0, 8'h76}, {3'd1, 4'hD, 1'b0, 8'h38},
        {3'd2, 4'hE, 1'b1, 8'hF3}, {3'd3, 4'hF, 1'b0, 8'h00}
    };

    logic [7:0] shadow [6];

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_digit(input logic [2:0] a, input logic [3:0] c,
                               input logic p, input logic sel_n);
        @(negedge clk);
        addr_i = a; bcd_i = c; dp_i = p; ce_n_i = sel_n; we_n_i = 1'b0;
        repeat (3) @(negedge clk);
        we_n_i = 1'b1;
        repeat (2) @(negedge clk);
        ce_n_i = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic read_digit(input int d, input logic [7:0] exp, input string req);
        int n = 0;
        @(negedge clk);
        while (digit_sel_o !== (6'd1 << d) && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(digit_sel_o === (6'd1 << d), {req, " select"}, digit_sel_o, 6'd1 << d);
        check(seg_o === exp, {req, " segments"}, seg_o, exp);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin : main
        logic [5:0] prev;
        logic [7:0] seg_hold;
        bit ok;
        int n;

        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: right after reset the scan is in its dark gap
        check(digit_sel_o === 6'd0, "R1 select", digit_sel_o, 0);
        check(seg_o === 8'h00, "R1 segments", seg_o, 0);
        for (int d = 0; d < 6; d++) read_digit(d, 8'h00, "R1 blank contents");

        // Table walk: R2 R5 R6 R7
        for (int v = 0; v < NV; v++) begin
            write_digit(VEC[v][15:13], VEC[v][12:9], VEC[v][8], 1'b0);
            shadow[VEC[v][15:13]] = VEC[v][7:0];
            read_digit(int'(VEC[v][15:13]), VEC[v][7:0], "R2 R5 R6 R7 table");
        end

        // R3: null positions
        write_digit(3'd6, 4'h8, 1'b1, 1'b0);
        write_digit(3'd7, 4'h0, 1'b0, 1'b0);
        for (int d = 0; d < 6; d++) read_digit(d, shadow[d], "R3 null write");

        // R4: select high blocks
        write_digit(3'd3, 4'h1, 1'b0, 1'b1);
        read_digit(3, shadow[3], "R4 select high");

        // R2: code and position change in the release cycle
        @(negedge clk);
        addr_i = 3'd4; bcd_i = 4'h2; dp_i = 1'b0; ce_n_i = 1'b0; we_n_i = 1'b0;
        repeat (3) @(negedge clk);
        we_n_i = 1'b1; addr_i = 3'd5; bcd_i = 4'h8;
        repeat (2) @(negedge clk);
        ce_n_i = 1'b1;
        repeat (6) @(negedge clk);
        shadow[4] = 8'h5B;
        read_digit(4, 8'h5B, "R2 no hold old value");
        read_digit(5, shadow[5], "R2 no hold new position untouched");

        // R8: order and wrap
        n = 0;
        @(negedge clk);
        while (digit_sel_o == 6'd0) @(negedge clk);
        prev = digit_sel_o;
        ok = 1'b1;
        for (int k = 0; k < 8; k++) begin
            while (digit_sel_o != 6'd0) @(negedge clk);
            while (digit_sel_o == 6'd0) @(negedge clk);
            if (digit_sel_o !== ((prev == 6'b100000) ? 6'd1 : prev << 1)) ok = 1'b0;
            prev = digit_sel_o;
        end
        check(ok, "R8 scan order", prev, 0);

        // R9: gap and lit lengths
        while (digit_sel_o != 6'd0) @(negedge clk);
        n = 0;
        while (digit_sel_o == 6'd0) begin n++; @(negedge clk); end
        check(n == BT, "R9 dark gap length", n, BT);
        n = 0;
        while (digit_sel_o != 6'd0) begin n++; @(negedge clk); end
        check(n == DT - BT, "R9 lit length", n, DT - BT);

        // R10: freeze while lit
        read_digit(2, shadow[2], "R10 pre-freeze");
        freeze_i = 1'b1;
        seg_hold = seg_o;
        ok = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (digit_sel_o !== 6'b000100 || seg_o !== seg_hold) ok = 1'b0;
        end
        check(ok, "R10 frozen output", digit_sel_o, 6'b000100);
        freeze_i = 1'b0;

        // R11: segments off, scan continues
        seg_off_i = 1'b1;
        for (int d = 0; d < 6; d++) read_digit(d, 8'h00, "R11 segments off");
        check(seg_oe_o === 1'b0, "R11 enable low", seg_oe_o, 0);

        // R12: standby
        freeze_i = 1'b1;
        @(negedge clk);
        prev = digit_sel_o;
        ok = 1'b1;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (digit_sel_o !== prev || seg_o !== 8'h00) ok = 1'b0;
        end
        check(ok, "R12 standby", seg_o, 0);
        freeze_i = 1'b0;
        seg_off_i = 1'b0;
        read_digit(0, shadow[0], "R12 resume");
        check(seg_oe_o === 1'b1, "R11 enable restored", seg_oe_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule